// File: doc/BRIEF.md
# Slow-Clock System Timer

This block is the system timebase of a chip. It keeps a free-running real-time counter that advances at a rate set by a programmable divider of the 32768 Hz slow clock. Next to the counter sit an absolute-match alarm and a periodic interval timer that reloads itself. All of them report through a four-flag status register that is cleared by reading it. Separate write-one enable and disable registers control an interrupt mask, and a single level interrupt is raised while any enabled flag is pending.

The block runs on the bus clock. Each cycle of the slow clock arrives as a one-cycle strobe on `slow_tick_i`, already brought into the bus clock domain. A watchdog elsewhere reports overflow on `wdog_ovf_i`, and this block keeps only its status flag. Software reads the counter through a snapshot stage. The stage moves a value across only once two successive samples agree, so a read never returns a value that is changing mid-update.

Register byte offsets (5-bit address): 0x00 period, 0x04 prescaler, 0x08 status, 0x0C mask enable, 0x10 mask disable, 0x14 mask (read), 0x18 alarm, 0x1C counter (read). Writes to read-only offsets and reads of write-only offsets have no effect and return 0.

Top module: `slow_timer`

## Requirements
- R1: After reset the mask is 0, all status flags are 0, the counter reads 0, the alarm register reads all ones (CNT_W bits), the prescaler reads 32768 and `irq_o` is low.
- R2: With prescaler value P (1..65535), the counter advances once every P slow ticks. Writing the prescaler clears the counter to 0 and restarts the division.
- R3: The counter is CNT_W bits wide (20 by default) and wraps from all ones to 0.
- R4: Alarm flag (status bit 3) sets only on the increment that makes the counter equal the alarm register; writing the alarm with the current count delays the flag by a full 2^CNT_W increments.
- R5: With period value N (1..65535), periodic flag (status bit 0) sets on every N-th slow tick. The timer then reloads, and writing the period restarts it.
- R6: Status bits: bit 0 periodic, bit 1 watchdog overflow (set by a `wdog_ovf_i` pulse), bit 2 counter increment, bit 3 alarm; a status read returns the flags and clears them.
- R7: Writing 1 to a bit of offset 0x0C sets that mask bit, writing 1 to offset 0x10 clears it, and 0 bits leave the mask unchanged. Offset 0x14 reads the mask in bits 3:0.
- R8: `irq_o` is high exactly while some status flag is set and its mask bit is 1.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe. A counter read (offset 0x1C) made 3 or more cycles after the last increment returns the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle strobe per slow-clock cycle |
| wdog_ovf_i | input | 1 | Watchdog overflow pulse |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
A divider or interval counter left in a wrong state shows up as a counter value or a periodic flag that lands one or more ticks away from the expected tick. It is visible at the first status or counter read after that tick. A bad alarm compare either raises bit 3 early or misses it, and the cycle-by-cycle alarm-equality assertion flags it in the cycle after the increment. A mask or flag register in error drives `irq_o` wrong in the same cycle. A stale snapshot returns the old count on a read made three cycles after the last tick.

// File: rtl/slow_timer_pkg.sv
package slow_timer_pkg;
  localparam int NFLAG = 4;
  localparam int FL_PIT = 0;
  localparam int FL_WDG = 1;
  localparam int FL_INC = 2;
  localparam int FL_ALM = 3;

  localparam logic [4:0] OFS_PERIOD = 5'h00;
  localparam logic [4:0] OFS_PRESC  = 5'h04;
  localparam logic [4:0] OFS_STATUS = 5'h08;
  localparam logic [4:0] OFS_IEN    = 5'h0C;
  localparam logic [4:0] OFS_IDIS   = 5'h10;
  localparam logic [4:0] OFS_MASK   = 5'h14;
  localparam logic [4:0] OFS_ALARM  = 5'h18;
  localparam logic [4:0] OFS_COUNT  = 5'h1C;

  typedef logic [NFLAG-1:0] flags_t;
endpackage

// File: rtl/st_reload_div.sv
module st_reload_div #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] reload_i,
  output logic         fire_o
);
  localparam logic [W-1:0] ONE = W'(1);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    fire_o = 1'b0;
    if (load_i) begin
      cnt_d = reload_i;
    end else if (tick_i) begin
      if (cnt_q == ONE) begin
        fire_o = 1'b1;
        cnt_d  = reload_i;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else if (load_i || tick_i) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/st_rtc.sv
module st_rtc #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_i,
  input  logic             clear_i,
  input  logic             alarm_wr_i,
  input  logic [CNT_W-1:0] alarm_wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] alarm_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [CNT_W-1:0] alarm_q;

  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    cnt_d = cnt_q;
    hit_o = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (inc_i) begin
      cnt_d = cnt_inc;
      hit_o = (cnt_inc == alarm_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clear_i || inc_i) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '1;
    else if (alarm_wr_i) alarm_q <= alarm_wdata_i;
  end

  assign cnt_o   = cnt_q;
  assign alarm_o = alarm_q;
endmodule

// File: rtl/st_snap.sv
module st_snap #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q, q_q, q_d;
  logic         agree;

  assign agree = (s1_q == s2_q);

  always_comb begin
    q_d = q_q;
    if (agree) q_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      q_q  <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      q_q  <= q_d;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/slow_timer.sv
module slow_timer
  import slow_timer_pkg::*;
#(
  parameter int CNT_W   = 20,
  parameter int PRE_W   = 16,
  parameter int PIT_W   = 16,
  parameter int PRE_RST = 32768,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick_i,
  input  logic              wdog_ovf_i,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [4:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int = rsync_q[1];

  logic wr, rd;
  assign wr = bus_en && bus_we;
  assign rd = bus_en && !bus_we;

  logic wr_period, wr_presc, wr_ien, wr_idis, wr_alarm, rd_status;
  assign wr_period = wr && (bus_addr == OFS_PERIOD);
  assign wr_presc  = wr && (bus_addr == OFS_PRESC);
  assign wr_ien    = wr && (bus_addr == OFS_IEN);
  assign wr_idis   = wr && (bus_addr == OFS_IDIS);
  assign wr_alarm  = wr && (bus_addr == OFS_ALARM);
  assign rd_status = rd && (bus_addr == OFS_STATUS);

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  // programmed values
  logic [PIT_W-1:0] period_q, period_d;
  logic [PRE_W-1:0] presc_q, presc_d;
  always_comb begin
    period_d = period_q;
    presc_d  = presc_q;
    if (wr_period) period_d = bus_wdata[PIT_W-1:0];
    if (wr_presc)  presc_d  = bus_wdata[PRE_W-1:0];
  end
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      period_q <= '0;
      presc_q  <= PRE_W'(PRE_RST);
    end else begin
      if (wr_period) period_q <= period_d;
      if (wr_presc)  presc_q  <= presc_d;
    end
  end

  // prescaler and periodic interval timer share one reload divider design
  logic inc_pulse, pit_pulse;
  st_reload_div #(.W(PRE_W), .RST_VAL(PRE_RST)) u_prediv (
    .clk(clk), .rst_n(rst_int), .tick_i(slow_tick_i),
    .load_i(wr_presc), .reload_i(presc_d), .fire_o(inc_pulse));

  st_reload_div #(.W(PIT_W), .RST_VAL(0)) u_pit (
    .clk(clk), .rst_n(rst_int), .tick_i(slow_tick_i),
    .load_i(wr_period), .reload_i(period_d), .fire_o(pit_pulse));

  logic [CNT_W-1:0] rtc_cnt, rtc_alarm, rtc_snap;
  logic             alarm_hit;
  st_rtc #(.CNT_W(CNT_W)) u_rtc (
    .clk(clk), .rst_n(rst_int), .inc_i(inc_pulse), .clear_i(wr_presc),
    .alarm_wr_i(wr_alarm), .alarm_wdata_i(bus_wdata[CNT_W-1:0]),
    .cnt_o(rtc_cnt), .alarm_o(rtc_alarm), .hit_o(alarm_hit));

  st_snap #(.W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_int), .d_i(rtc_cnt), .q_o(rtc_snap));

  // status flags and interrupt mask
  flags_t set_vec, flags_q, flags_d, mask_q, mask_d;
  always_comb begin
    set_vec         = '0;
    set_vec[FL_PIT] = pit_pulse;
    set_vec[FL_WDG] = wdog_ovf_i;
    set_vec[FL_INC] = inc_pulse;
    set_vec[FL_ALM] = alarm_hit;
    flags_d = (rd_status ? '0 : flags_q) | set_vec;
    mask_d  = mask_q;
    if (wr_ien)  mask_d = mask_d | bus_wdata[NFLAG-1:0];
    if (wr_idis) mask_d = mask_d & ~bus_wdata[NFLAG-1:0];
  end
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      flags_q <= '0;
      mask_q  <= '0;
    end else begin
      flags_q <= flags_d;
      if (wr_ien || wr_idis) mask_q <= mask_d;
    end
  end

  assign irq_o = |(flags_q & mask_q);

  // registered read path
  logic [DATA_W-1:0] rdata_q, rdata_d;
  always_comb begin
    rdata_d = '0;
    unique case (bus_addr)
      OFS_PERIOD: rdata_d = DATA_W'(period_q);
      OFS_PRESC:  rdata_d = DATA_W'(presc_q);
      OFS_STATUS: rdata_d = DATA_W'(flags_q);
      OFS_MASK:   rdata_d = DATA_W'(mask_q);
      OFS_ALARM:  rdata_d = DATA_W'(rtc_alarm);
      OFS_COUNT:  rdata_d = DATA_W'(rtc_snap);
      default:    rdata_d = '0;
    endcase
  end
  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int)  rdata_q <= '0;
    else if (rd)   rdata_q <= rdata_d;
  end
  assign bus_rdata = rdata_q;
endmodule

// File: rtl/slow_timer_chk.sv
module slow_timer_chk
  import slow_timer_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [4:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input flags_t            flags_q,
  input flags_t            mask_q,
  input flags_t            set_vec,
  input logic [CNT_W-1:0]  rtc_cnt,
  input logic [CNT_W-1:0]  rtc_alarm
);
  logic wr_any, rd_stat;
  assign wr_any  = bus_en && bus_we;
  assign rd_stat = bus_en && !bus_we && (bus_addr == OFS_STATUS);

  AST_ALARM_ON_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[FL_ALM]) |-> (rtc_cnt == rtc_alarm)); // R4

  AST_PRESC_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_PRESC) |=> (rtc_cnt == '0)); // R2

  AST_COUNT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rtc_cnt) |-> (rtc_cnt == $past(rtc_cnt) + CNT_W'(1) || rtc_cnt == '0)); // R3

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && set_vec == '0) |=> (flags_q == '0)); // R6

  AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && bus_addr == OFS_IEN) |=>
      ((mask_q & $past(bus_wdata[NFLAG-1:0])) == $past(bus_wdata[NFLAG-1:0]))); // R7

  AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o); // R8
endmodule

bind slow_timer slow_timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_int), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .irq_o(irq_o),
  .flags_q(flags_q), .mask_q(mask_q), .set_vec(set_vec),
  .rtc_cnt(rtc_cnt), .rtc_alarm(rtc_alarm));

// File: tb/slow_timer_bench.sv
module slow_timer_bench;
  localparam int CW = 10;
  localparam int MOD = 1 << CW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slow_tick_i = 1'b0;
  logic        wdog_ovf_i = 1'b0;
  logic        bus_en = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  slow_timer #(.CNT_W(CW)) u_slow_timer (
    .clk(clk), .rst_n(rst_n), .slow_tick_i(slow_tick_i), .wdog_ovf_i(wdog_ovf_i),
    .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    slow_tick_i = 1'b1;
    repeat (n) @(negedge clk);
    slow_tick_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] v;
    check("R1 irq", {31'b0, irq_o}, 32'd0);
    rd(5'h08, v); check("R1 status", v, 32'd0);
    rd(5'h14, v); check("R1 mask", v, 32'd0);
    rd(5'h1C, v); check("R1 counter", v, 32'd0);
    rd(5'h18, v); check("R1 alarm", v, MOD - 1);
    rd(5'h04, v); check("R1 prescaler", v, 32'd32768);
  endtask

  task automatic test_prescale();
    logic [31:0] v;
    wr(5'h04, 32'd3);
    ticks(7);
    rd(5'h1C, v); check("R2 P=3 after 7 ticks", v, 32'd2);
    rd(5'h08, v); check("R6 increment flag", v & 32'h4, 32'h4);
    rd(5'h08, v); check("R6 cleared by read", v, 32'd0);
    wr(5'h04, 32'd1);
    repeat (4) @(negedge clk);
    rd(5'h1C, v); check("R2 write clears counter", v, 32'd0);
    ticks(5);
    rd(5'h1C, v); check("R2 R9 P=1 after 5 ticks", v, 32'd5);
  endtask

  task automatic test_wrap();
    logic [31:0] v;
    wr(5'h04, 32'd1);
    ticks(MOD);
    rd(5'h1C, v); check("R3 wrap to zero", v, 32'd0);
    ticks(2);
    rd(5'h1C, v); check("R3 after wrap", v, 32'd2);
  endtask

  task automatic test_alarm();
    logic [31:0] v;
    wr(5'h04, 32'd1);
    wr(5'h18, 32'd5);
    rd(5'h08, v);
    ticks(4);
    rd(5'h08, v); check("R4 no alarm before match", v, 32'h4);
    ticks(1);
    rd(5'h08, v); check("R4 alarm at match", v, 32'hC);
    wr(5'h18, 32'd5);
    rd(5'h08, v); check("R6 status empty", v, 32'd0);
    ticks(MOD - 1);
    rd(5'h08, v); check("R4 current-value alarm not yet", v, 32'h4);
    ticks(1);
    rd(5'h08, v); check("R4 alarm after full wrap", v, 32'hC);
  endtask

  task automatic test_periodic();
    logic [31:0] v;
    wr(5'h00, 32'd4);
    rd(5'h08, v);
    ticks(3);
    rd(5'h08, v); check("R5 periodic not yet", v, 32'h4);
    ticks(1);
    rd(5'h08, v); check("R5 periodic at 4", v, 32'h5);
    ticks(4);
    rd(5'h08, v); check("R5 periodic reload", v, 32'h5);
  endtask

  task automatic test_wdog();
    logic [31:0] v;
    wdog_ovf_i = 1'b1; @(negedge clk); wdog_ovf_i = 1'b0;
    rd(5'h08, v); check("R6 watchdog flag", v, 32'h2);
    rd(5'h08, v); check("R6 watchdog cleared", v, 32'h0);
  endtask

  task automatic test_mask();
    logic [31:0] v;
    wr(5'h0C, 32'h9);
    rd(5'h14, v); check("R7 enable", v, 32'h9);
    wr(5'h0C, 32'h0);
    rd(5'h14, v); check("R7 enable zero no effect", v, 32'h9);
    wr(5'h10, 32'h1);
    rd(5'h14, v); check("R7 disable", v, 32'h8);
    wr(5'h10, 32'h0);
    rd(5'h14, v); check("R7 disable zero no effect", v, 32'h8);
    check("R8 idle irq low", {31'b0, irq_o}, 32'd0);
    wdog_ovf_i = 1'b1; @(negedge clk); wdog_ovf_i = 1'b0;
    check("R8 masked flag no irq", {31'b0, irq_o}, 32'd0);
    wr(5'h0C, 32'h2);
    check("R8 enabled flag irq", {31'b0, irq_o}, 32'd1);
    rd(5'h08, v);
    check("R8 irq drops after read", {31'b0, irq_o}, 32'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_prescale();
    test_wrap();
    test_alarm();
    test_periodic();
    test_wdog();
    test_mask();
    done = 1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule